// File: doc/BRIEF.md
# MMU and Exception Control Register Block

This block holds the translation and exception control state of a processor core and answers 32-bit host accesses to it. Nine registers live in the local register file: the MMU control word, the page-table-entry high, low and assistance words, the translation table base, the exception address, the trap code, and the exception and interrupt event codes. Some writes have side effects. A write to the control word can pulse a TLB invalidate-all strobe. A write to the page-table-entry high word pulses a TLB flush strobe when its address-space ID changes.

A second address space, the array window, is selected by `req_win`. It decodes three address bits into eight region types. Four of them are cache address/data regions, which read as zero and absorb writes. The other four are TLB address/data regions, which are forwarded to an external TLB port through a request/acknowledge handshake and carry the full address.

The host raises `req_valid` for one cycle while the block is idle. It then waits for the one-cycle `resp_done` pulse before issuing the next access.

Top module: `mmu_exc_regs`

## Requirements
- R1: After reset every register reads as zero and `resp_done`, `resp_err`, `tlb_inval`, `tlb_flush` and `tlb_req` are low.
- R2: Writing the control word (offset 0) stores the data with bit 2 forced to 0. If bit 2 of the written data is 1, `tlb_inval` is high for exactly the response cycle.
- R3: Writing the PTE-high word (offset 1) stores all 32 bits. `tlb_flush` is high in the response cycle only when written bits 7:0 differ from the stored bits 7:0.
- R4: The PTE-assistance word (offset 3) keeps only bits 3:0 of a write; the other bits read as 0.
- R5: The trap code (offset 6), exception event (offset 7) and interrupt event (offset 8) words keep only bits 10:0 of a write.
- R6: The PTE-low (offset 2), table base (offset 4) and exception address (offset 5) words store all 32 bits.
- R7: With `req_win`=0 the register is chosen by `req_addr[5:2]`, and the other address bits are ignored. Offsets 9 to 15 read as zero and writes to them change nothing.
- R8: A `req_size` other than 2'b10 (32-bit) gives `resp_done` with `resp_err`=1 and `resp_rdata`=0. It changes no register, raises no strobe and raises no `tlb_req`.
- R9: With `req_win`=1, `req_addr[26:24]` selects the region in this order: 0 I-cache address, 1 I-cache data, 2 ITLB address, 3 ITLB data, 4 O-cache address, 5 O-cache data, 6 UTLB address, 7 UTLB data. Regions 0, 1, 4 and 5 respond with data 0, have no effect and raise no `tlb_req`.
- R10: Regions 2, 3, 6 and 7 raise `tlb_req` in the cycle after acceptance, with `tlb_addr`, `tlb_write` and `tlb_wdata` taken from the request. `tlb_req` is held until `tlb_ack`. `resp_done` follows one cycle after the acknowledge, with `tlb_rdata` on a read and 0 on a write.
- R11: A local access (register file, cache region or size error) gives `resp_done` in the cycle after the accepting edge. A register read returns its value and a write returns data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, one cycle, only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = register file, 1 = array window |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | Access size, 2'b10 = 32-bit |
| req_wdata | input | 32 | Write data |
| resp_done | output | 1 | Response pulse |
| resp_err | output | 1 | Size error flag, valid with `resp_done` |
| resp_rdata | output | 32 | Read data, valid with `resp_done` |
| tlb_inval | output | 1 | Invalidate-all strobe to the TLB |
| tlb_flush | output | 1 | Flush strobe on address-space ID change |
| tlb_req | output | 1 | Forwarded TLB access request |
| tlb_write | output | 1 | Forwarded access is a write |
| tlb_addr | output | 32 | Forwarded full address |
| tlb_wdata | output | 32 | Forwarded write data |
| tlb_ack | input | 1 | TLB acknowledge |
| tlb_rdata | input | 32 | TLB read data, valid with `tlb_ack` |

## Verification
A wrong stored value stays hidden until the host reads that offset back. The bench therefore follows every masked write with reads, both directed and random, and compares the whole word. A stale stored address-space ID shows up as a missing or extra `tlb_flush` on the very next PTE-high write. A decode error shows up in the same response cycle: a `tlb_req` that should not be there, a `tlb_req` that never comes, or a response that arrives without waiting for the acknowledge.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

    localparam int NUM_REGS = 9;
    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [3:0] {
        IDX_CTRL = 4'd0,
        IDX_PTEH = 4'd1,
        IDX_PTEL = 4'd2,
        IDX_PTEA = 4'd3,
        IDX_TTB  = 4'd4,
        IDX_TEA  = 4'd5,
        IDX_TRAP = 4'd6,
        IDX_EXC  = 4'd7,
        IDX_INT  = 4'd8
    } reg_idx_e;

    typedef enum logic [2:0] {
        RG_ICACHE_A = 3'd0,
        RG_ICACHE_D = 3'd1,
        RG_ITLB_A   = 3'd2,
        RG_ITLB_D   = 3'd3,
        RG_OCACHE_A = 3'd4,
        RG_OCACHE_D = 3'd5,
        RG_UTLB_A   = 3'd6,
        RG_UTLB_D   = 3'd7
    } region_e;

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_REG  = 3'd1,
        ACT_ZERO = 3'd2,
        ACT_TLB  = 3'd3,
        ACT_ERR  = 3'd4
    } act_e;

endpackage

// File: rtl/mmu_acc_decode.sv
module mmu_acc_decode
    import mmu_regs_pkg::*;
(
    input  logic       valid,
    input  logic       win,
    input  logic [1:0] size,
    input  logic [2:0] region,
    output act_e       act
);

    logic tlb_region;

    always_comb begin
        case (region_e'(region))
            RG_ITLB_A, RG_ITLB_D, RG_UTLB_A, RG_UTLB_D: tlb_region = 1'b1;
            default:                                    tlb_region = 1'b0;
        endcase
    end

    always_comb begin
        if (!valid)                 act = ACT_NONE;
        else if (size != SIZE_WORD) act = ACT_ERR;
        else if (!win)              act = ACT_REG;
        else if (tlb_region)        act = ACT_TLB;
        else                        act = ACT_ZERO;
    end

    always_comb begin
        if (act == ACT_TLB) assert_tlb_only_in_window_R9: assert (win && size == SIZE_WORD);
    end

endmodule

// File: rtl/mmu_ctl_bank.sv
module mmu_ctl_bank
    import mmu_regs_pkg::*;
#(
    parameter int NREG     = NUM_REGS,
    parameter int IDX_W    = 4,
    parameter int ASID_W   = 8,
    parameter int EVT_W    = 11,
    parameter int ASSIST_W = 4,
    parameter int INV_BIT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic             inval_o,
    output logic             flush_o
);

    localparam logic [IDX_W-1:0] NREG_L      = IDX_W'(NREG);
    localparam logic [31:0]      ASSIST_MASK = 32'((64'd1 << ASSIST_W) - 64'd1);
    localparam logic [31:0]      EVT_MASK    = 32'((64'd1 << EVT_W) - 64'd1);
    localparam logic [31:0]      CTRL_MASK   = ~(32'd1 << INV_BIT);
    localparam logic [IDX_W-1:0] I_CTRL      = IDX_W'(IDX_CTRL);
    localparam logic [IDX_W-1:0] I_PTEH      = IDX_W'(IDX_PTEH);
    localparam logic [IDX_W-1:0] I_PTEA      = IDX_W'(IDX_PTEA);
    localparam logic [IDX_W-1:0] I_TRAP      = IDX_W'(IDX_TRAP);
    localparam logic [IDX_W-1:0] I_EXC       = IDX_W'(IDX_EXC);
    localparam logic [IDX_W-1:0] I_INT       = IDX_W'(IDX_INT);

    typedef struct packed {
        logic [NREG-1:0][31:0] regs;
        logic                  inval;
        logic                  flush;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [31:0] keep_mask(input logic [IDX_W-1:0] idx);
        if (idx == I_CTRL)                                return CTRL_MASK;
        if (idx == I_PTEA)                                return ASSIST_MASK;
        if (idx == I_TRAP || idx == I_EXC || idx == I_INT) return EVT_MASK;
        return '1;
    endfunction

    always_comb begin
        bank_d       = bank_q;
        bank_d.inval = 1'b0;
        bank_d.flush = 1'b0;
        if (wr_en && wr_idx < NREG_L) begin
            bank_d.regs[wr_idx] = wdata & keep_mask(wr_idx);
            if (wr_idx == I_CTRL) bank_d.inval = wdata[INV_BIT];
            if (wr_idx == I_PTEH)
                bank_d.flush = wdata[ASID_W-1:0] != bank_q.regs[I_PTEH][ASID_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_data = (rd_idx < NREG_L) ? bank_q.regs[rd_idx] : '0;
    assign inval_o = bank_q.inval;
    assign flush_o = bank_q.flush;

    assert_flush_on_asid_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.flush |-> bank_q.regs[I_PTEH][ASID_W-1:0] != $past(bank_q.regs[I_PTEH][ASID_W-1:0]));

    assert_ctrl_bit_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.inval |-> !bank_q.regs[I_CTRL][INV_BIT] && $changed(bank_q.inval) || $past(bank_q.inval));

endmodule

// File: rtl/mmu_tlb_bridge.sv
module mmu_tlb_bridge #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          tlb_req,
    output logic          tlb_write,
    output logic [AW-1:0] tlb_addr,
    output logic [DW-1:0] tlb_wdata,
    input  logic          tlb_ack,
    output logic          fin
);

    typedef struct packed {
        logic          req;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } fwd_t;

    fwd_t fwd_d, fwd_q;

    always_comb begin
        fwd_d = fwd_q;
        if (fwd_q.req) begin
            if (tlb_ack) fwd_d.req = 1'b0;
        end else if (start) begin
            fwd_d.req   = 1'b1;
            fwd_d.write = write;
            fwd_d.addr  = addr;
            fwd_d.wdata = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fwd_q <= '0;
        else        fwd_q <= fwd_d;
    end

    assign tlb_req   = fwd_q.req;
    assign tlb_write = fwd_q.write;
    assign tlb_addr  = fwd_q.addr;
    assign tlb_wdata = fwd_q.wdata;
    assign fin       = fwd_q.req && tlb_ack;

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q.req && !tlb_ack |=> fwd_q.req && $stable(fwd_q.addr) && $stable(fwd_q.write));

    assert_req_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q.req && tlb_ack |=> !fwd_q.req);

endmodule

// File: rtl/mmu_exc_regs.sv
module mmu_exc_regs
    import mmu_regs_pkg::*;
#(
    parameter int IDX_LSB    = 2,
    parameter int IDX_W      = 4,
    parameter int REGION_LSB = 24,
    parameter int ASID_W     = 8,
    parameter int EVT_W      = 11,
    parameter int ASSIST_W   = 4,
    parameter int INV_BIT    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_win,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        resp_done,
    output logic        resp_err,
    output logic [31:0] resp_rdata,
    output logic        tlb_inval,
    output logic        tlb_flush,
    output logic        tlb_req,
    output logic        tlb_write,
    output logic [31:0] tlb_addr,
    output logic [31:0] tlb_wdata,
    input  logic        tlb_ack,
    input  logic [31:0] tlb_rdata
);

    typedef struct packed {
        logic        busy;
        logic        done;
        logic        err;
        logic [31:0] rdata;
    } top_t;

    top_t top_d, top_q;

    act_e             act;
    logic             accept;
    logic [IDX_W-1:0] idx;
    logic [31:0]      bank_rd;
    logic             fin;

    assign accept = req_valid && !top_q.busy;
    assign idx    = req_addr[IDX_LSB +: IDX_W];

    mmu_acc_decode u_dec (
        .valid  (accept),
        .win    (req_win),
        .size   (req_size),
        .region (req_addr[REGION_LSB +: 3]),
        .act    (act)
    );

    mmu_ctl_bank #(
        .NREG     (NUM_REGS),
        .IDX_W    (IDX_W),
        .ASID_W   (ASID_W),
        .EVT_W    (EVT_W),
        .ASSIST_W (ASSIST_W),
        .INV_BIT  (INV_BIT)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (act == ACT_REG && req_write),
        .wr_idx  (idx),
        .wdata   (req_wdata),
        .rd_idx  (idx),
        .rd_data (bank_rd),
        .inval_o (tlb_inval),
        .flush_o (tlb_flush)
    );

    mmu_tlb_bridge #(.AW(32), .DW(32)) u_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (act == ACT_TLB),
        .write     (req_write),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .tlb_req   (tlb_req),
        .tlb_write (tlb_write),
        .tlb_addr  (tlb_addr),
        .tlb_wdata (tlb_wdata),
        .tlb_ack   (tlb_ack),
        .fin       (fin)
    );

    always_comb begin
        top_d       = top_q;
        top_d.done  = 1'b0;
        top_d.err   = 1'b0;
        top_d.rdata = '0;
        case (act)
            ACT_REG: begin
                top_d.done  = 1'b1;
                top_d.rdata = req_write ? '0 : bank_rd;
            end
            ACT_ZERO: top_d.done = 1'b1;
            ACT_ERR: begin
                top_d.done = 1'b1;
                top_d.err  = 1'b1;
            end
            ACT_TLB: top_d.busy = 1'b1;
            default: ;
        endcase
        if (fin) begin
            top_d.busy  = 1'b0;
            top_d.done  = 1'b1;
            top_d.rdata = tlb_write ? '0 : tlb_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign resp_done  = top_q.done;
    assign resp_err   = top_q.err;
    assign resp_rdata = top_q.rdata;

    assert_quiet_while_forwarding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req |-> !resp_done);

    assert_err_has_no_side_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_done && resp_rdata == '0 && !tlb_inval && !tlb_flush && !tlb_req);

endmodule

// File: tb/mmu_exc_regs_bench.sv
module mmu_exc_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_win = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        resp_done, resp_err;
    logic [31:0] resp_rdata;
    logic        tlb_inval, tlb_flush, tlb_req, tlb_write;
    logic [31:0] tlb_addr, tlb_wdata;
    logic        tlb_ack = 1'b0;
    logic [31:0] tlb_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] model [0:8];

    always #5 clk = ~clk;

    mmu_exc_regs u_mmu_exc_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_win(req_win), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .tlb_inval(tlb_inval), .tlb_flush(tlb_flush), .tlb_req(tlb_req),
        .tlb_write(tlb_write), .tlb_addr(tlb_addr), .tlb_wdata(tlb_wdata),
        .tlb_ack(tlb_ack), .tlb_rdata(tlb_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] keep(input int idx);
        case (idx)
            0:       return 32'hFFFF_FFFB;
            3:       return 32'h0000_000F;
            6, 7, 8: return 32'h0000_07FF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string reg_tag(input int idx);
        case (idx)
            0:       return "R2";
            1:       return "R3";
            3:       return "R4";
            6, 7, 8: return "R5";
            2, 4, 5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // One complete access; starts and ends at a falling edge.
    task automatic op(input bit win, input bit wr, input logic [31:0] addr,
                      input logic [1:0] sz, input logic [31:0] wd, input int ackdly);
        bit          size_ok = (sz == 2'b10);
        bit          fwd = size_ok && win && addr[25];
        int          idx = int'(addr[5:2]);
        logic [31:0] trd = $urandom;
        logic [31:0] exp_rd = '0;
        bit          exp_inv = 0, exp_fl = 0;
        string       tag;
        if (!size_ok)  tag = "R8";
        else if (fwd)  tag = "R10";
        else if (win)  tag = "R9";
        else           tag = reg_tag(idx);
        if (size_ok && !win) begin
            if (wr) begin
                exp_inv = (idx == 0) && wd[2];
                exp_fl  = (idx == 1) && (wd[7:0] != model[1][7:0]);
                if (idx < 9) model[idx] = wd & keep(idx);
            end else begin
                exp_rd = (idx < 9) ? model[idx] : 32'h0;
            end
        end
        if (fwd && !wr) exp_rd = trd;
        req_valid = 1'b1; req_write = wr; req_win = win;
        req_addr = addr; req_size = sz; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (fwd) begin
            chk(tlb_req == 1'b1, "R10 tlb_req raised", 32'(tlb_req), 32'd1);
            chk(tlb_addr == addr && tlb_write == wr && (!wr || tlb_wdata == wd),
                "R10 forwarded fields", tlb_addr, addr);
            for (int k = 0; k < ackdly; k++) begin
                chk(tlb_req && !resp_done, "R10 held until ack", 32'(resp_done), 32'd0);
                @(posedge clk); @(negedge clk);
            end
            tlb_ack = 1'b1; tlb_rdata = trd;
            @(posedge clk); @(negedge clk);
            tlb_ack = 1'b0;
            chk(!tlb_req, "R10 request dropped after ack", 32'(tlb_req), 32'd0);
        end else begin
            chk(!tlb_req, {tag, " no tlb_req"}, 32'(tlb_req), 32'd0);
        end
        chk(resp_done == 1'b1, {tag, " R11 done timing"}, 32'(resp_done), 32'd1);
        chk(resp_err == !size_ok, {tag, " err flag"}, 32'(resp_err), 32'(!size_ok));
        chk(resp_rdata == exp_rd, {tag, " read data"}, resp_rdata, exp_rd);
        chk(tlb_inval == exp_inv, {tag, " invalidate strobe"}, 32'(tlb_inval), 32'(exp_inv));
        chk(tlb_flush == exp_fl, {tag, " flush strobe"}, 32'(tlb_flush), 32'(exp_fl));
        @(posedge clk); @(negedge clk);
        chk(!resp_done && !tlb_inval && !tlb_flush, {tag, " pulses last one cycle"},
            {29'd0, resp_done, tlb_inval, tlb_flush}, 32'd0);
    endtask

    function automatic logic [31:0] raddr(input int idx);
        return {$urandom} & 32'hFFFF_FFC3 | (32'(idx) << 2);
    endfunction

    function automatic logic [31:0] waddr(input int region);
        return ({$urandom} & 32'hF8FF_FFFF) | (32'(region) << 24);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed_unused;
        seed_unused = $urandom(32'd4242);
        for (int i = 0; i < 9; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports, then every register reads zero
        chk(!resp_done && !resp_err && !tlb_inval && !tlb_flush && !tlb_req, "R1 outputs idle",
            {27'd0, resp_done, resp_err, tlb_inval, tlb_flush, tlb_req}, 32'd0);
        for (int i = 0; i < 9; i++) op(0, 0, raddr(i), 2'b10, 0, 0);
        // R2: invalidate bit self-clears
        op(0, 1, raddr(0), 2'b10, 32'hFFFF_FFFF, 0);
        op(0, 0, raddr(0), 2'b10, 0, 0);
        op(0, 1, raddr(0), 2'b10, 32'h0000_0001, 0);
        op(0, 0, raddr(0), 2'b10, 0, 0);
        // R3: flush only on ID change
        op(0, 1, raddr(1), 2'b10, 32'h1234_5678, 0);
        op(0, 1, raddr(1), 2'b10, 32'hABCD_E678, 0);
        op(0, 0, raddr(1), 2'b10, 0, 0);
        op(0, 1, raddr(1), 2'b10, 32'hABCD_E679, 0);
        // R4, R5, R6 masking
        for (int i = 2; i < 9; i++) begin
            op(0, 1, raddr(i), 2'b10, 32'hFFFF_FFFF, 0);
            op(0, 0, raddr(i), 2'b10, 0, 0);
        end
        // R7: unmapped offsets
        op(0, 1, raddr(12), 2'b10, 32'hDEAD_BEEF, 0);
        op(0, 0, raddr(12), 2'b10, 0, 0);
        op(0, 0, raddr(4), 2'b10, 0, 0);
        // R8: bad sizes change nothing
        op(0, 1, raddr(4), 2'b01, 32'h0, 0);
        op(0, 0, raddr(4), 2'b10, 0, 0);
        op(1, 0, waddr(6), 2'b00, 0, 0);
        op(0, 1, raddr(0), 2'b11, 32'h4, 0);
        // R9 and R10: every region
        for (int r = 0; r < 8; r++) begin
            op(1, 0, waddr(r), 2'b10, 0, r % 4);
            op(1, 1, waddr(r), 2'b10, $urandom, 3 - (r % 4));
        end
        // random mix
        for (int n = 0; n < 400; n++) begin
            int   kind = $urandom % 10;
            bit   wr = 1'($urandom);
            int   dly = $urandom % 4;
            if (kind == 0) begin
                logic [1:0] sz = 2'($urandom % 3);
                if (sz == 2'b10) sz = 2'b11;
                op(1'($urandom), wr, $urandom, sz, $urandom, 0);
            end else if (kind < 3) begin
                op(1, wr, waddr($urandom % 8), 2'b10, $urandom, dly);
            end else begin
                int ix = (kind == 9) ? ($urandom % 16) : ($urandom % 9);
                logic [31:0] wv = $urandom;
                if ($urandom % 3 == 0) wv[7:0] = model[1][7:0];
                op(0, wr, raddr(ix), 2'b10, wv, 0);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule